// File: doc/BRIEF.md
# JTAG Scan Chain Sequencer

This block is the host end of a JTAG link. It turns short commands into the TCK, TMS and TDI waveforms for a chain of several test access ports and samples TDO while it shifts. A command is one of three kinds: a chain reset, an instruction-register scan or a data-register scan. A scan carries a bit count and a shift vector of up to `MAX_BITS` bits. The caller builds the whole-chain vector itself. It places each device's field next to the others, with the device nearest TDO in the lowest bits, and gives every bypassed device one bit in the data path.

The sequencer keeps its own copy of the TAP controller state, which is either Test-Logic-Reset or Run-Test/Idle between commands. From that state it picks the shortest TMS path into the shift state. It then shifts the vector out least significant bit first, drives TMS high on the final bit, and walks through Update back to Run-Test/Idle. Each bit read from TDO during the shift is stored, and the whole captured vector is presented together with a one-cycle `done` pulse. TCK is made by dividing the system clock. TMS and TDI move only on the falling edge of TCK, and TDO is sampled on the rising edge.

Top module: `jtag_scan_seq`

## Requirements
- R1: Command code 0 (reset) drives TMS high for exactly 7 TCK cycles. It leaves the tracked state in Test-Logic-Reset and clears `rdata` to zero.
- R2: A scan that starts from Test-Logic-Reset first drives TMS 0,1,1,0,0 for an instruction scan (code 1), or 0,1,0,0 for a data scan (code 2).
- R3: A scan that starts from Run-Test/Idle first drives TMS 1,1,0,0 for an instruction scan, or 1,0,0 for a data scan.
- R4: During the shift, TDI presents the command vector least significant bit first. TMS is low for every bit except the last one, where it is high.
- R5: After the last shifted bit, TMS is driven 1 then 0, so the chain ends in Run-Test/Idle. A scan therefore takes entry length + bit count + 2 TCK cycles.
- R6: Bit i of `rdata` is the TDO level at the rising TCK edge of shifted bit i. Bits at or above the bit count read zero. `rdata` stays unchanged while `busy` is low.
- R7: The TCK period is 2×(TCK_DIV+1) system clocks. TMS and TDI change only while TCK is low, and TCK stays low while the block is idle.
- R8: `busy` rises in the cycle after a command is accepted and falls right after the single cycle in which `done` is high. Commands presented while `busy` is high are ignored.
- R9: A bit count of 0 shifts one bit. A bit count above `MAX_BITS` shifts `MAX_BITS` bits.
- R10: Command code 3 is ignored: `busy` stays low and TCK does not toggle.
- R11: After system reset, `busy`, `done` and TCK are low. The tracked state is Test-Logic-Reset, so the first scan uses the entry path of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when the block is idle |
| cmd_kind | input | 2 | 0 reset, 1 instruction scan, 2 data scan, 3 ignored |
| cmd_len | input | $clog2(MAX_BITS)+1 | Number of bits to shift |
| cmd_data | input | MAX_BITS | Whole-chain shift vector, LSB shifted first |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | MAX_BITS | Captured TDO vector |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data toward the chain |
| tdo | input | 1 | Test data from the chain |

## Verification
The hardest behaviour to reach from the ports is the choice of entry path. It depends on what the earlier command left behind, not on the command now being issued. The stimulus therefore fixes the order of commands: a scan straight after power-up, a data scan straight after a reset command, and random mixes of all three kinds, so that every pairing of previous state and scan kind occurs. A small TAP model in the bench follows TMS on every TCK edge and feeds TDO from a known pattern. A second hard case is a command strobed in the middle of a scan; one scan carries such an intruding reset, and the bench confirms that the chain still ends in Run-Test/Idle.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

    typedef enum logic [1:0] {
        CMD_RESET = 2'd0,
        CMD_IR    = 2'd1,
        CMD_DR    = 2'd2,
        CMD_NONE  = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RST,
        PH_PRE,
        PH_SHIFT,
        PH_POST,
        PH_DONE
    } phase_e;

    localparam int RESET_STEPS = 7;
    localparam int POST_STEPS  = 2;

    // TMS entry path, bit 0 is driven first
    typedef struct packed {
        logic [4:0] bits;
        logic [2:0] len;
    } tms_path_t;

    function automatic tms_path_t entry_path(input logic is_ir, input logic from_tlr);
        tms_path_t p;
        unique case ({is_ir, from_tlr})
            2'b11:   p = '{bits: 5'b00110, len: 3'd5};
            2'b10:   p = '{bits: 5'b00011, len: 3'd4};
            2'b01:   p = '{bits: 5'b00010, len: 3'd4};
            default: p = '{bits: 5'b00001, len: 3'd3};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/jscan_tckgen.sv
module jscan_tckgen #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tck,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (DIV > 0) ? $clog2(DIV + 1) : 1;

    logic [CW-1:0] div_cnt;
    logic          tck_q;
    logic          term;

    assign term = (div_cnt == CW'(DIV));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt <= '0;
            tck_q   <= 1'b0;
        end else if (term) begin
            div_cnt <= '0;
            tck_q   <= ~tck_q;
        end else begin
            div_cnt <= div_cnt + CW'(1);
        end
    end

    assign tck      = tck_q;
    assign rise_evt = run && term && !tck_q;
    assign fall_evt = run && term && tck_q;

endmodule

// File: rtl/jscan_shifter.sv
module jscan_shifter #(
    parameter int W     = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [W-1:0]     load_data,
    input  logic             advance,
    input  logic             capture,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic             tdo,
    output logic             tx_bit,
    output logic [W-1:0]     rx_data
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
        end else if (advance) begin
            tx_q <= tx_q >> 1;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst || load) begin
                rx_q[i] <= 1'b0;
            end else if (capture && (cap_idx == IDX_W'(i))) begin
                rx_q[i] <= tdo;
            end
        end
    end

    assign tx_bit  = tx_q[0];
    assign rx_data = rx_q;

endmodule

// File: rtl/jscan_stepper.sv
module jscan_stepper
    import jscan_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = 6,
    parameter int IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             rise_evt,
    input  logic             fall_evt,
    input  logic             tx_bit,
    output logic             run,
    output logic             busy,
    output logic             done,
    output logic             tms,
    output logic             tdi,
    output logic             load,
    output logic             step_shift,
    output logic             step_capture,
    output logic [IDX_W-1:0] bit_idx
);
    localparam int CNT_W = (LEN_W > 3) ? LEN_W : 4;

    phase_e          phase;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] eff_len;
    tms_path_t        path;
    logic             at_tlr;
    logic             last_step;
    logic             accept;
    cmd_kind_e        kind;

    assign kind   = cmd_kind_e'(cmd_kind);
    assign accept = (phase == PH_IDLE) && cmd_valid && (kind != CMD_NONE);

    always_comb begin
        if (cmd_len == '0) begin
            eff_len = LEN_W'(1);
        end else if (cmd_len > LEN_W'(MAX_BITS)) begin
            eff_len = LEN_W'(MAX_BITS);
        end else begin
            eff_len = cmd_len;
        end
    end

    always_comb begin
        unique case (phase)
            PH_RST:   last_step = (cnt == CNT_W'(RESET_STEPS - 1));
            PH_PRE:   last_step = (cnt == CNT_W'(path.len) - CNT_W'(1));
            PH_SHIFT: last_step = (cnt == CNT_W'(len_q) - CNT_W'(1));
            PH_POST:  last_step = (cnt == CNT_W'(POST_STEPS - 1));
            default:  last_step = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            len_q  <= LEN_W'(1);
            path   <= '0;
            at_tlr <= 1'b1;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        cnt <= '0;
                        if (kind == CMD_RESET) begin
                            phase <= PH_RST;
                        end else begin
                            phase <= PH_PRE;
                            path  <= entry_path(kind == CMD_IR, at_tlr);
                            len_q <= eff_len;
                        end
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: begin
                    if (fall_evt) begin
                        if (!last_step) begin
                            cnt <= cnt + CNT_W'(1);
                        end else begin
                            cnt <= '0;
                            unique case (phase)
                                PH_RST: begin
                                    phase  <= PH_DONE;
                                    at_tlr <= 1'b1;
                                end
                                PH_PRE:   phase <= PH_SHIFT;
                                PH_SHIFT: phase <= PH_POST;
                                default: begin
                                    phase  <= PH_DONE;
                                    at_tlr <= 1'b0;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (phase)
            PH_RST:   tms = 1'b1;
            PH_PRE:   tms = path.bits[cnt[2:0]];
            PH_SHIFT: tms = last_step;
            PH_POST:  tms = (cnt == '0);
            default:  tms = 1'b0;
        endcase
    end

    assign tdi          = (phase == PH_SHIFT) ? tx_bit : 1'b0;
    assign run          = (phase != PH_IDLE) && (phase != PH_DONE);
    assign busy         = (phase != PH_IDLE);
    assign done         = (phase == PH_DONE);
    assign load         = accept;
    assign step_shift   = fall_evt && (phase == PH_SHIFT);
    assign step_capture = rise_evt && (phase == PH_SHIFT);
    assign bit_idx      = cnt[IDX_W-1:0];

endmodule

// File: rtl/jtag_scan_seq.sv
module jtag_scan_seq #(
    parameter int MAX_BITS = 32,
    parameter int TCK_DIV  = 1,
    localparam int LEN_W   = $clog2(MAX_BITS) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_kind,
    input  logic [LEN_W-1:0]    cmd_len,
    input  logic [MAX_BITS-1:0] cmd_data,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rdata,
    output logic                tck,
    output logic                tms,
    output logic                tdi,
    input  logic                tdo
);
    localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

    logic             run;
    logic             rise_evt;
    logic             fall_evt;
    logic             load;
    logic             step_shift;
    logic             step_capture;
    logic             tx_bit;
    logic [IDX_W-1:0] bit_idx;

    jscan_tckgen #(.DIV(TCK_DIV)) u_tck (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tck      (tck),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    jscan_stepper #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_step (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_kind     (cmd_kind),
        .cmd_len      (cmd_len),
        .rise_evt     (rise_evt),
        .fall_evt     (fall_evt),
        .tx_bit       (tx_bit),
        .run          (run),
        .busy         (busy),
        .done         (done),
        .tms          (tms),
        .tdi          (tdi),
        .load         (load),
        .step_shift   (step_shift),
        .step_capture (step_capture),
        .bit_idx      (bit_idx)
    );

    jscan_shifter #(.W(MAX_BITS), .IDX_W(IDX_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (cmd_data),
        .advance   (step_shift),
        .capture   (step_capture),
        .cap_idx   (bit_idx),
        .tdo       (tdo),
        .tx_bit    (tx_bit),
        .rx_data   (rdata)
    );

endmodule

// File: rtl/jscan_seq_chk.sv
module jscan_seq_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         busy,
    input logic         done,
    input logic         tck,
    input logic         tms,
    input logic         tdi,
    input logic [W-1:0] rdata
);
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    p_tck_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tck);

    p_tms_moves_low_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(tms) |-> !tck);

    p_tdi_moves_low_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(tdi) |-> !tck);

    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> $stable(rdata));

endmodule

bind jtag_scan_seq jscan_seq_chk #(.W(MAX_BITS)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .busy  (busy),
    .done  (done),
    .tck   (tck),
    .tms   (tms),
    .tdi   (tdi),
    .rdata (rdata)
);

// File: tb/jtag_scan_seq_tb_top.sv
module jtag_scan_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int MAXB       = 32;
    localparam int LW         = $clog2(MAXB) + 1;
    localparam longint TCK_T  = 2 * (DIV + 1) * CLK_PERIOD;

    typedef enum int {
        S_TLR, S_RTI, S_SDR, S_CDR, S_SHD, S_E1D, S_PDR, S_E2D, S_UDR,
        S_SIR, S_CIR, S_SHI, S_E1I, S_PIR, S_E2I, S_UIR
    } tap_e;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_valid = 1'b0;
    logic [1:0]      cmd_kind = 2'd0;
    logic [LW-1:0]   cmd_len = '0;
    logic [MAXB-1:0] cmd_data = '0;
    logic            busy, done, tck, tms, tdi, tdo;
    logic [MAXB-1:0] rdata;

    logic [MAXB-1:0] tdo_vec = '0;
    tap_e            tap_st = S_TLR;
    int              nstep = 0;
    int              nshift = 0;
    int              bad_per = 0;
    longint          last_rise = 0;
    bit              tms_log [128];
    bit              tdi_log [64];
    int              checks = 0;
    int              errors = 0;

    jtag_scan_seq #(.MAX_BITS(MAXB), .TCK_DIV(DIV)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_len   (cmd_len),
        .cmd_data  (cmd_data),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .tck       (tck),
        .tms       (tms),
        .tdi       (tdi),
        .tdo       (tdo)
    );

    assign tdo = tdo_vec[0];

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    function automatic tap_e next_st(input tap_e s, input logic m);
        case (s)
            S_TLR:   return m ? S_TLR : S_RTI;
            S_RTI:   return m ? S_SDR : S_RTI;
            S_SDR:   return m ? S_SIR : S_CDR;
            S_CDR:   return m ? S_E1D : S_SHD;
            S_SHD:   return m ? S_E1D : S_SHD;
            S_E1D:   return m ? S_UDR : S_PDR;
            S_PDR:   return m ? S_E2D : S_PDR;
            S_E2D:   return m ? S_UDR : S_SHD;
            S_UDR:   return m ? S_SDR : S_RTI;
            S_SIR:   return m ? S_TLR : S_CIR;
            S_CIR:   return m ? S_E1I : S_SHI;
            S_SHI:   return m ? S_E1I : S_SHI;
            S_E1I:   return m ? S_UIR : S_PIR;
            S_PIR:   return m ? S_E2I : S_PIR;
            S_E2I:   return m ? S_UIR : S_SHI;
            default: return m ? S_SDR : S_RTI;
        endcase
    endfunction

    // chain model: follows TMS, records TDI in shift states, advances TDO source
    always @(posedge tck) begin
        if (nstep > 0 && (longint'($time) - last_rise) != TCK_T) bad_per++;
        last_rise = longint'($time);
        if (nstep < 128) tms_log[nstep] = tms;
        nstep++;
        if (tap_st == S_SHD || tap_st == S_SHI) begin
            if (nshift < 64) tdi_log[nshift] = tdi;
            nshift++;
            tdo_vec = tdo_vec >> 1;
        end
        tap_st = next_st(tap_st, tms);
    end

    task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", msg, act, exp);
        end
    endtask

    // expected TMS at step i, from R1..R5
    function automatic bit exp_tms(input int k, input bit tlr, input int eff, input int i);
        int       pre;
        bit [4:0] pb;
        if (k == 0) return 1'b1;
        if (k == 1) begin
            pre = tlr ? 5 : 4;
            pb  = tlr ? 5'b00110 : 5'b00011;
        end else begin
            pre = tlr ? 4 : 3;
            pb  = tlr ? 5'b00010 : 5'b00001;
        end
        if (i < pre) return pb[i];
        if (i < pre + eff) return (i == pre + eff - 1);
        return (i == pre + eff);
    endfunction

    task automatic run_cmd(input int k, input int len, input logic [31:0] d,
                           input logic [31:0] tp, input bit intrude);
        int          eff, pre, total, wait_n;
        bit          tlr;
        logic [31:0] mask, got;
        longint      a_tms, e_tms;
        eff   = (len == 0) ? 1 : ((len > MAXB) ? MAXB : len);
        tlr   = (tap_st == S_TLR);
        pre   = (k == 1) ? (tlr ? 5 : 4) : (tlr ? 4 : 3);
        total = (k == 0) ? 7 : pre + eff + 2;
        mask  = (eff >= 32) ? 32'hFFFF_FFFF : ((32'd1 << eff) - 32'd1);
        nstep = 0; nshift = 0; bad_per = 0; tdo_vec = tp;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k[1:0]; cmd_len = LW'(len); cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", longint'(busy), 1);
        wait_n = 0;
        while (!done && wait_n < 5000) begin
            @(negedge clk);
            wait_n++;
            if (intrude && wait_n == 7) begin
                cmd_valid = 1'b1; cmd_kind = 2'd0;
            end else begin
                cmd_valid = 1'b0;
            end
        end
        cmd_valid = 1'b0;
        chk(done == 1'b1, "R8 done pulse seen", longint'(done), 1);
        a_tms = 0; e_tms = 0;
        for (int i = 0; i < total && i < 64; i++) begin
            a_tms[i] = tms_log[i];
            e_tms[i] = exp_tms(k, tlr, eff, i);
        end
        chk(nstep == total, (k == 0) ? "R1 TCK count" : "R5 TCK count", nstep, total);
        chk(a_tms == e_tms, (k == 0) ? "R1 TMS stream" : (tlr ? "R2 TMS stream" : "R3 TMS stream"),
            a_tms, e_tms);
        if (k == 0) begin
            chk(tap_st == S_TLR, "R1 end in reset state", int'(tap_st), int'(S_TLR));
            chk(rdata == '0, "R1 rdata cleared", longint'(rdata), 0);
        end else begin
            got = '0;
            for (int i = 0; i < eff; i++) got[i] = tdi_log[i];
            chk(tap_st == S_RTI, "R5 end in idle", int'(tap_st), int'(S_RTI));
            chk(nshift == eff, "R9 shifted bit count", nshift, eff);
            chk(got == (d & mask), "R4 TDI LSB first", longint'(got), longint'(d & mask));
            chk(rdata == (tp & mask), "R6 captured TDO", longint'(rdata), longint'(tp & mask));
        end
        chk(bad_per == 0, "R7 TCK period", bad_per, 0);
        @(negedge clk);
        chk(!done && !busy, "R8 single done then idle", longint'({done, busy}), 0);
        if (intrude) begin
            repeat (20) @(negedge clk);
            chk(nstep == total && !busy, "R8 command during busy ignored", nstep, total);
        end
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

    initial begin : main
        bit          ir_exp [9]  = '{0, 1, 1, 0, 1, 0, 0, 1, 1};
        bit          dr_exp [10] = '{0, 1, 0, 1, 0, 1, 1, 1, 1, 0};
        bit          ok;
        bit          saw_busy;
        logic [31:0] tp;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !tck, "R11 outputs after reset",
            longint'({busy, done, tck}), 0);

        // R11: first scan after power-up uses the reset-state entry (R2)
        run_cmd(1, 9, 32'h0000_0196, 32'h0000_00AB, 1'b0);
        ok = 1'b1;
        for (int i = 0; i < 9; i++) if (tdi_log[i] != ir_exp[i]) ok = 1'b0;
        chk(ok, "R4 three-device instruction stream", nshift, 9);

        // data scan from idle, 0xF5 in the middle device behind one bypass bit
        tp = 32'h0000_02C6;
        run_cmd(2, 10, 32'h0000_01EA, tp, 1'b0);
        ok = 1'b1;
        for (int i = 0; i < 10; i++) if (tdi_log[i] != dr_exp[i]) ok = 1'b0;
        chk(ok, "R3 data stream for 0xF5", nshift, 10);
        chk(rdata[8:1] == tp[8:1], "R6 middle device field", longint'(rdata[8:1]),
            longint'(tp[8:1]));

        run_cmd(0, 0, 32'h0, 32'h0, 1'b0);
        run_cmd(2, 5, 32'h0000_0013, 32'h0000_0015, 1'b0);   // R2 data entry
        run_cmd(0, 0, 32'h0, 32'h0, 1'b0);
        run_cmd(2, 32, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);  // R2 data entry, full width
        run_cmd(1, 0, 32'h0000_0001, 32'h0000_0001, 1'b0);   // R9 zero length
        run_cmd(2, 45, 32'hA5A5_5A5A, 32'hC3C3_3C3C, 1'b0);  // R9 clamp
        run_cmd(2, 12, 32'h0000_0ABC, 32'h0000_0F0F, 1'b1);  // R8 intruding command

        // R10: unused command code
        nstep = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'd3; cmd_len = LW'(8);
        @(negedge clk);
        cmd_valid = 1'b0;
        saw_busy = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (busy) saw_busy = 1'b1;
        end
        chk(!saw_busy && nstep == 0, "R10 code 3 ignored", longint'({saw_busy, 1'b0}) + nstep, 0);

        for (int n = 0; n < 30; n++) begin
            run_cmd(int'($urandom_range(0, 2)), int'($urandom_range(0, 40)),
                    $urandom, $urandom, 1'b0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

endmodule